// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 32 interrupt sources and drives two request lines toward a processor core. One is a normal request line and the other is a fast request line. Each line belongs to its own class. A class has a raw signal view, a mask of enable bits, a masked status view and a write-one-to-clear port for the enables. One source position (source 1) is reserved for a software-injected interrupt that bypasses the mask in both classes.

Each class can switch into vectored mode. In vectored mode, every source carries a 3-bit priority. The class picks the most urgent pending source and splices its index with a programmable base to form a vector address. A bus read of that vector address acknowledges the winner and pushes its priority onto an 8-entry nesting stack. A write to the class's end-of-service address pops the stack. While the stack holds an entry, the request line rises only for a source that strictly outranks the entry on top.

Registers sit on a simple synchronous bus. Writes take effect on the clock edge. Read data is a combinational view of the addressed register.

Top module: `vic_top`

Register word addresses (on `bus_addr`):
- Normal class: 0x00 status, 0x01 raw, 0x02 enable-set, 0x03 enable-clear.
- Fast class: 0x04 status, 0x05 raw, 0x06 enable-set, 0x07 enable-clear.
- Shared: 0x08 software, 0x09 control, 0x0A base.
- Vectors: 0x0B normal vector, 0x0C fast vector.
- End-of-service: 0x0D normal, 0x0E fast.
- 0x0F nesting state.
- 0x10 to 0x13 priorities.

## Requirements
- R1: The status of a class reads as its raw bits ANDed with its enable bits. The software position is the exception and always shows through.
- R2: With vectoring off for a class (control bit 0 for the normal class, bit 1 for the fast class), the class request is the OR of its status bits, and its vector reads as 0.
- R3: Writing 1s to the enable-set address sets enable bits, and the enable-set address reads back the enables. Writing 1s to the enable-clear address clears enable bits. A 0 in an enable-clear write changes nothing.
- R4: In the software register, bit 1 drives raw and status bit 1 of the normal class, and bit 2 drives the same bit of the fast class. This happens regardless of enables and raises the request line. All other bits of the software register read as 0.
- R5: A source rising at the inputs first appears in the raw register after the third rising clock edge: two synchronizer stages, then the pending register.
- R6: The four priority registers hold 8 sources each. Register 0x10+r, field k (bits 4k+2 to 4k), is the priority of source 8r+k. The other bits read as 0. All priorities reset to 0.
- R7: Among pending status bits, the lowest priority value wins. On equal values, the lower source index wins.
- R8: The vector word is laid out as follows: bits 31:23 are 0, bits 22:7 hold the base, bits 6:2 hold the winning index, and bits 1:0 are 0.
- R9: The base register resets to 0, keeps only bits 15:0 and reads 0 in bits 31:16.
- R10: A bus read of a vectored class's vector address with a winner present pushes the winner's priority onto the class's stack. The request is then asserted only if the winner's value is strictly below the top entry.
- R11: A write to the class's end-of-service address pops one entry. A pop on an empty stack has no effect.
- R12: A push onto a full 8-entry stack is dropped and sets a sticky overflow flag. The nesting register carries the normal class's depth in bits 3:0 and its overflow flag in bit 4. It carries the fast class's depth in bits 11:8 and its overflow flag in bit 12.
- R13: The two classes keep separate enables, vectoring controls and stacks, and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (acknowledges on vector addresses) |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |

## Verification
The bench builds the block with its defaults: 32 sources, 3-bit priorities, a depth of 8 and two synchronizer stages. With these values the vector fields fall exactly at bits 22:7 and 6:2, so absolute vector words can be checked. The stack depth of eight means the bench can reach the overflow case with nine acknowledge reads and then drain the stack with eight pops. The bench covers:
- the three-edge input latency;
- a priority tie;
- a strictly-higher preemption during nesting;
- fast-class traffic while the normal stack is loaded.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // word addresses of the register file
    localparam logic [7:0] A_CLS_STRIDE = 8'h04; // per-class block: stat, raw, ens, enc
    localparam logic [7:0] A_SWI        = 8'h08;
    localparam logic [7:0] A_CTRL       = 8'h09;
    localparam logic [7:0] A_BASE       = 8'h0A;
    localparam logic [7:0] A_VEC0       = 8'h0B;
    localparam logic [7:0] A_EOI0       = 8'h0D;
    localparam logic [7:0] A_NEST       = 8'h0F;
    localparam logic [7:0] A_PRIO0      = 8'h10;

    localparam int NCLS       = 2;  // 0 = normal, 1 = fast
    localparam int FLD_PER_RG = 8;  // priority fields per register
    localparam int FLD_STRIDE = 4;  // bit stride of a priority field
    localparam int SWI_POS    = 1;  // source position of the software interrupt

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic ack;
        logic eoi;
    } cls_ctl_t;

    function automatic logic [7:0] cls_addr(int cls, int off);
        return 8'(cls) * A_CLS_STRIDE + 8'(off);
    endfunction

endpackage

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC*PW-1:0] prio_i,
    output logic               valid_o,
    output logic [IW-1:0]      idx_o,
    output logic [PW-1:0]      prio_o
);

    // descending scan with <= lets the lower index win a tie
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (!valid_o || prio_i[i*PW +: PW] <= prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i*PW +: PW];
            end
        end
    end

    p_win_pending_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> pend_i[idx_o]);

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        p_win_best_r7: assert property (@(posedge clk) disable iff (rst)
            (valid_o && pend_i[g]) |->
            (prio_o < prio_i[g*PW +: PW] ||
             (prio_o == prio_i[g*PW +: PW] && idx_o <= IW'(g))));
    end

endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
    parameter int DEPTH = 8,
    parameter int PW    = 3,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int XW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [PW-1:0] din_i,
    output logic [PW-1:0] top_o,
    output logic          empty_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);

    logic [PW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          full;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign cnt_o   = cnt_q;
    assign ovf_o   = ovf_q;
    assign top_o   = empty_o ? '0 : mem_q[XW'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (push_i) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                mem_q[XW'(cnt_q)] <= din_i;
                cnt_q             <= cnt_q + 1'b1;
            end
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_full_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> (ovf_o && $stable(cnt_q)));
    p_push_grow_r10: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_pop_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> (cnt_q == '0));

endmodule

// File: rtl/vic_class.sv
module vic_class
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(NSRC),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    pend_i,
    input  logic               swi_i,
    input  logic [NSRC-1:0]    wdata_i,
    input  cls_ctl_t           ctl_i,
    input  logic               vect_en_i,
    input  logic [NSRC*PW-1:0] prio_i,
    output logic [NSRC-1:0]    raw_o,
    output logic [NSRC-1:0]    stat_o,
    output logic [NSRC-1:0]    en_o,
    output logic               req_o,
    output logic [IW-1:0]      idx_o,
    output logic [CW-1:0]      cnt_o,
    output logic               ovf_o
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] swi_vec;
    logic            win_valid;
    logic [PW-1:0]   win_prio;
    logic [PW-1:0]   top_prio;
    logic            stk_empty;

    assign swi_vec = {{(NSRC-1){1'b0}}, swi_i} << SWI_POS;
    assign raw_o   = pend_i | swi_vec;
    assign stat_o  = (raw_o & en_q) | swi_vec;
    assign en_o    = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | (ctl_i.en_set ? wdata_i : '0))
                  & ~(ctl_i.en_clr ? wdata_i : '0);
        end
    end

    vic_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (stat_o),
        .prio_i  (prio_i),
        .valid_o (win_valid),
        .idx_o   (idx_o),
        .prio_o  (win_prio)
    );

    vic_nest #(.DEPTH(DEPTH), .PW(PW)) u_nest (
        .clk     (clk),
        .rst     (rst),
        .push_i  (ctl_i.ack && vect_en_i && win_valid),
        .pop_i   (ctl_i.eoi),
        .din_i   (win_prio),
        .top_o   (top_prio),
        .empty_o (stk_empty),
        .cnt_o   (cnt_o),
        .ovf_o   (ovf_o)
    );

    always_comb begin
        if (vect_en_i) req_o = win_valid && (stk_empty || win_prio < top_prio);
        else           req_o = |stat_o;
    end

    p_unmasked_swi_r4: assert property (@(posedge clk) disable iff (rst)
        swi_i |-> stat_o[SWI_POS]);
    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.en_clr && !ctl_i.en_set) |=> ((en_q & $past(wdata_i)) == '0));
    p_nest_block_r10: assert property (@(posedge clk) disable iff (rst)
        (vect_en_i && req_o && !stk_empty) |-> (win_prio < top_prio));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PW     = 3,
    parameter int DEPTH  = 8,
    parameter int SYNC   = 2,
    parameter int BASE_W = 16,
    localparam int DW    = 32,
    localparam int IW    = $clog2(NSRC),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NPREG = NSRC / FLD_PER_RG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);

    logic [NSRC-1:0]    sync_q [SYNC];
    logic [NSRC-1:0]    pend_q;
    logic [NCLS-1:0]    swi_q;
    logic [NCLS-1:0]    vect_q;
    logic [BASE_W-1:0]  base_q;
    logic [NSRC*PW-1:0] prio_q;

    logic [NSRC-1:0] raw_w  [NCLS];
    logic [NSRC-1:0] stat_w [NCLS];
    logic [NSRC-1:0] en_w   [NCLS];
    logic            req_w  [NCLS];
    logic [IW-1:0]   idx_w  [NCLS];
    logic [CW-1:0]   cnt_w  [NCLS];
    logic            ovf_w  [NCLS];
    logic [DW-1:0]   vec_w  [NCLS];
    cls_ctl_t        ctl_w  [NCLS];

    // input qualification: SYNC stages then the pending register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
            pend_q <= '0;
        end else begin
            sync_q[0] <= src_i;
            for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
            pend_q <= sync_q[SYNC-1];
        end
    end

    // shared configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            swi_q  <= '0;
            vect_q <= '0;
            base_q <= '0;
            prio_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_SWI)  swi_q  <= bus_wdata[SWI_POS +: NCLS];
            if (bus_addr == A_CTRL) vect_q <= bus_wdata[NCLS-1:0];
            if (bus_addr == A_BASE) base_q <= bus_wdata[BASE_W-1:0];
            for (int r = 0; r < NPREG; r++) begin
                if (bus_addr == A_PRIO0 + 8'(r)) begin
                    for (int k = 0; k < FLD_PER_RG; k++)
                        prio_q[(r*FLD_PER_RG + k)*PW +: PW] <= bus_wdata[k*FLD_STRIDE +: PW];
                end
            end
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign ctl_w[c].en_set = bus_wr && bus_addr == cls_addr(c, 2);
        assign ctl_w[c].en_clr = bus_wr && bus_addr == cls_addr(c, 3);
        assign ctl_w[c].ack    = bus_rd && bus_addr == A_VEC0 + 8'(c);
        assign ctl_w[c].eoi    = bus_wr && bus_addr == A_EOI0 + 8'(c);

        vic_class #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) u_cls (
            .clk       (clk),
            .rst       (rst),
            .pend_i    (pend_q),
            .swi_i     (swi_q[c]),
            .wdata_i   (bus_wdata[NSRC-1:0]),
            .ctl_i     (ctl_w[c]),
            .vect_en_i (vect_q[c]),
            .prio_i    (prio_q),
            .raw_o     (raw_w[c]),
            .stat_o    (stat_w[c]),
            .en_o      (en_w[c]),
            .req_o     (req_w[c]),
            .idx_o     (idx_w[c]),
            .cnt_o     (cnt_w[c]),
            .ovf_o     (ovf_w[c])
        );

        assign vec_w[c] = vect_q[c]
            ? ((DW'(base_q) << (IW + 2)) | (DW'(idx_w[c]) << 2))
            : '0;

        p_vec_frame_r8: assert property (@(posedge clk) disable iff (rst)
            (vec_w[c][1:0] == 2'b00) && (vec_w[c][DW-1:BASE_W+IW+2] == '0));
    end

    assign irq_o = req_w[0];
    assign fiq_o = req_w[1];

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (bus_addr == cls_addr(c, 0)) bus_rdata = DW'(stat_w[c]);
            if (bus_addr == cls_addr(c, 1)) bus_rdata = DW'(raw_w[c]);
            if (bus_addr == cls_addr(c, 2)) bus_rdata = DW'(en_w[c]);
            if (bus_addr == A_VEC0 + 8'(c)) bus_rdata = vec_w[c];
        end
        if (bus_addr == A_SWI)  bus_rdata = DW'(swi_q) << SWI_POS;
        if (bus_addr == A_CTRL) bus_rdata = DW'(vect_q);
        if (bus_addr == A_BASE) bus_rdata = DW'(base_q);
        if (bus_addr == A_NEST) begin
            bus_rdata[CW-1:0]  = cnt_w[0];
            bus_rdata[4]       = ovf_w[0];
            bus_rdata[8 +: CW] = cnt_w[1];
            bus_rdata[12]      = ovf_w[1];
        end
        for (int r = 0; r < NPREG; r++) begin
            if (bus_addr == A_PRIO0 + 8'(r)) begin
                for (int k = 0; k < FLD_PER_RG; k++)
                    bus_rdata[k*FLD_STRIDE +: PW] = prio_q[(r*FLD_PER_RG + k)*PW +: PW];
            end
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(sync_q[SYNC-1])) == '0));

endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src_i;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk; // 125 MHz

    vic_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    localparam logic [7:0] I_STAT = 8'h00, I_RAW = 8'h01, I_ENS = 8'h02, I_ENC = 8'h03;
    localparam logic [7:0] F_STAT = 8'h04, F_ENS = 8'h06;
    localparam logic [7:0] SWI = 8'h08, CTRL = 8'h09, BASE = 8'h0A;
    localparam logic [7:0] I_VEC = 8'h0B, F_VEC = 8'h0C, I_EOI = 8'h0D, NEST = 8'h0F;
    localparam logic [7:0] PR0 = 8'h10, PR1 = 8'h11;

    function automatic logic [31:0] vec_of(logic [15:0] b, int idx);
        return (32'(b) << 7) | (32'(idx) << 2);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        peek(I_STAT, d); chk_eq("R1 reset status", d, 0);
        peek(BASE, d);   chk_eq("R9 reset base", d, 0);
        peek(PR0, d);    chk_eq("R6 reset prio", d, 0);
        peek(NEST, d);   chk_eq("R12 reset nest", d, 0);
        chk_eq("R2 reset irq_o", 32'(irq_o), 0);
        chk_eq("R2 reset fiq_o", 32'(fiq_o), 0);
    endtask

    task automatic t_swi;
        logic [31:0] d;
        wr(SWI, 32'hFFFF_FFFF);
        peek(SWI, d);    chk_eq("R4 swi readback", d, 32'h6);
        peek(I_RAW, d);  chk_eq("R4 irq raw", d, 32'h2);
        peek(I_STAT, d); chk_eq("R4 irq status unmasked", d, 32'h2);
        peek(F_STAT, d); chk_eq("R4 fiq status unmasked", d, 32'h2);
        chk_eq("R4 irq_o", 32'(irq_o), 1);
        chk_eq("R4 fiq_o", 32'(fiq_o), 1);
        wr(SWI, 0);
        chk_eq("R4 irq_o drops", 32'(irq_o), 0);
    endtask

    task automatic t_latency_mask;
        logic [31:0] d;
        bus_addr = I_RAW;
        src_i[4] = 1'b1;
        edges(1); peek(I_RAW, d); chk_eq("R5 edge1", d, 0);
        edges(1); peek(I_RAW, d); chk_eq("R5 edge2", d, 0);
        edges(1); peek(I_RAW, d); chk_eq("R5 edge3", d, 32'h10);
        peek(I_STAT, d); chk_eq("R1 masked", d, 0);
        chk_eq("R2 masked no req", 32'(irq_o), 0);
        wr(I_ENS, 32'h0000_0010);
        peek(I_ENS, d);  chk_eq("R3 enable set", d, 32'h10);
        peek(I_STAT, d); chk_eq("R1 enabled", d, 32'h10);
        chk_eq("R2 flat req", 32'(irq_o), 1);
        wr(I_ENC, 32'h0);
        peek(I_ENS, d);  chk_eq("R3 clear zero no effect", d, 32'h10);
        wr(I_ENC, 32'h10);
        peek(I_ENS, d);  chk_eq("R3 clear", d, 0);
        chk_eq("R3 req gone", 32'(irq_o), 0);
        src_i[4] = 1'b0;
        edges(4);
    endtask

    task automatic t_vector;
        logic [31:0] d;
        wr(BASE, 32'hFFFF_ABCD);
        peek(BASE, d); chk_eq("R9 base width", d, 32'h0000_ABCD);
        wr(PR0, 32'hFFFF_FFFF);
        peek(PR0, d);  chk_eq("R6 field layout", d, 32'h7777_7777);
        wr(PR0, 32'h0330_0000);   // src5=3, src6=3
        wr(PR1, 32'h0000_0020);   // src9=2
        peek(I_VEC, d); chk_eq("R2 vector off", d, 0);
        wr(I_ENS, 32'hFFFF_FFFF);
        src_i[5] = 1'b1; src_i[6] = 1'b1; src_i[9] = 1'b1;
        edges(4);
        wr(CTRL, 32'h1);
        peek(I_VEC, d); chk_eq("R7 lowest value wins", d, vec_of(16'hABCD, 9));
        chk_eq("R8 exact word", d, 32'h0055_E6A4);
        chk_eq("R10 idle req", 32'(irq_o), 1);
        wr(PR1, 32'h0000_0030);   // src9=3, tie
        peek(I_VEC, d); chk_eq("R7 tie lower index", d, vec_of(16'hABCD, 5));
    endtask

    task automatic t_nest;
        logic [31:0] d;
        ack(I_VEC, d);  chk_eq("R10 ack vector", d, vec_of(16'hABCD, 5));
        peek(NEST, d);  chk_eq("R10 depth one", d, 32'h1);
        chk_eq("R10 equal blocked", 32'(irq_o), 0);
        wr(PR1, 32'h0000_0031);   // src8=1
        src_i[8] = 1'b1;
        edges(4);
        chk_eq("R10 higher preempts", 32'(irq_o), 1);
        peek(I_VEC, d); chk_eq("R10 preempt vector", d, vec_of(16'hABCD, 8));
        wr(I_EOI, 0);
        peek(NEST, d);  chk_eq("R11 pop", d, 0);
        wr(I_EOI, 0);
        peek(NEST, d);  chk_eq("R11 pop empty", d, 0);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        for (int i = 0; i < 9; i++) ack(I_VEC, d);
        peek(NEST, d);  chk_eq("R12 full and overflow", d, 32'h18);
        chk_eq("R12 blocked at top", 32'(irq_o), 0);
        for (int i = 0; i < 8; i++) wr(I_EOI, 0);
        peek(NEST, d);  chk_eq("R12 sticky overflow", d, 32'h10);
        chk_eq("R11 req back", 32'(irq_o), 1);
    endtask

    task automatic t_fast;
        logic [31:0] d;
        ack(I_VEC, d);
        peek(F_VEC, d); chk_eq("R13 fiq not vectored", d, 0);
        chk_eq("R13 fiq idle", 32'(fiq_o), 0);
        wr(F_ENS, 32'h0000_0200);
        peek(F_STAT, d); chk_eq("R13 fiq status", d, 32'h200);
        chk_eq("R13 fiq flat req", 32'(fiq_o), 1);
        wr(CTRL, 32'h3);
        peek(F_VEC, d); chk_eq("R13 fiq vector", d, vec_of(16'hABCD, 9));
        ack(F_VEC, d);
        peek(NEST, d);  chk_eq("R13 separate stacks", d, 32'h0000_0111);
        chk_eq("R13 fiq blocked", 32'(fiq_o), 0);
        chk_eq("R13 irq unaffected", 32'(irq_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; src_i = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        edges(3);
        rst = 1'b0;
        edges(1);
        t_reset();
        t_swi();
        t_latency_mask();
        t_vector();
        t_nest();
        t_overflow();
        t_fast();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule